// File: doc/BRIEF.md
# Sliced-Bitmap Ternary Match Unit

This block behaves like a small ternary content-addressable memory, but it stores no per-entry comparators. The 16-bit search key is cut into four 4-bit slices. Every slice indexes its own table of 16 rows, and each row is a 32-bit bitmap. Bit j of a row is set when entry j accepts that slice value. A search reads one row from each table and ANDs the four bitmaps together. The bits that survive mark the entries that match the whole key. A fixed-position priority picker then reports whether any entry matched and which one did.

Entries are programmed through a write port that takes an entry number, a value, a care mask and a set/clear flag. The write walks all 16 row addresses and updates bit j in every table in parallel, so one write occupies the unit for 16 cycles. A busy output covers that time, and searches and further writes offered while it is high are dropped. Several units can be placed in a chain. A unit that receives a hit from the unit before it passes that unit's ID onward instead of its own result, so entries in earlier units win.

Top module: `bmp_tcam_unit`

## Requirements
- R1: After reset, busy and res_valid are 0, and every table is empty, so any search reports res_hit = 0.
- R2: An entry stored with value V and care mask C (bit = 1 means compared, 0 means don't-care) matches key K exactly when ((K ^ V) & C) == 0. Key slice i is bits [4i+3:4i] and looks up only table i.
- R3: When several entries match, res_id is the lowest matching entry number.
- R4: When no entry matches and cas_hit_in was 0, res_hit is 0 and res_id is 0.
- R5: A search is accepted on a rising edge where srch_valid = 1 and busy = 0. Its result is on res_valid/res_hit/res_id after the second rising edge that follows, and res_valid is high for that one cycle.
- R6: A write accepted on a rising edge where wr_valid = 1 and busy = 0 raises busy for exactly 16 cycles. Busy drops after the edge that writes the last row.
- R7: A search offered while busy = 1 is dropped and produces no res_valid pulse.
- R8: A write offered while busy = 1 is dropped and leaves the stored entries unchanged.
- R9: A write with wr_enable = 0 removes the entry, so it matches no key afterwards.
- R10: If cas_hit_in = 1 when a search is accepted, the result is res_hit = 1 and res_id = cas_id_in, whatever the local match.
- R11: An entry whose care mask is all zero matches every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_valid | input | 1 | Search request |
| srch_key | input | 16 | Search key |
| cas_hit_in | input | 1 | Hit reported by the preceding unit in a chain |
| cas_id_in | input | 5 | ID from the preceding unit |
| wr_valid | input | 1 | Write request |
| wr_entry | input | 5 | Entry number to program |
| wr_value | input | 16 | Entry value |
| wr_care | input | 16 | Care mask, 1 = compared bit |
| wr_enable | input | 1 | 1 stores the entry, 0 removes it |
| busy | output | 1 | A write is in progress |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Some entry (or the chain) matched |
| res_id | output | 5 | Winning entry number |

## Verification
A search result is due two edges after it is accepted: the table read registers on the first edge and the AND/priority stage on the second. The bench drives each search on a falling edge. It checks that res_valid is still low at the next falling edge and samples the result one falling edge later. A write keeps busy high for 16 cycles from the edge after acceptance, so the bench counts the falling edges on which busy is seen high and expects 16. It offers blocked searches and writes only inside that window. For a blocked search, it watches res_valid for the two edges in which a result would have appeared.

// File: rtl/bmp_tcam_pkg.sv
package bmp_tcam_pkg;
  localparam int unsigned KEY_BITS   = 16;
  localparam int unsigned SLICE_BITS = 4;
  localparam int unsigned NUM_ENTRY  = 32;
endpackage

// File: rtl/bmp_part.sv
module bmp_part #(
  parameter int unsigned SLICE_W = 4,
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned ROWS = 1 << SLICE_W,
  localparam int unsigned ID_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLICE_W-1:0] rd_addr,
  output logic [ENTRIES-1:0] rd_row,
  input  logic               wr_on,
  input  logic [SLICE_W-1:0] wr_addr,
  input  logic [ID_W-1:0]    wr_ent,
  input  logic               wr_bit
);
  logic [ENTRIES-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      rd_row <= '0;
    end else begin
      rd_row <= mem[rd_addr];
      if (wr_on) mem[wr_addr][wr_ent] <= wr_bit;
    end
  end
endmodule

// File: rtl/bmp_writer.sv
module bmp_writer #(
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned SLICE_W = 4,
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned PARTS = KEY_W / SLICE_W,
  localparam int unsigned ROWS  = 1 << SLICE_W,
  localparam int unsigned ID_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [ID_W-1:0]    wr_entry,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_care,
  input  logic               wr_enable,
  output logic               busy,
  output logic [SLICE_W-1:0] row,
  output logic [ID_W-1:0]    ent,
  output logic [PARTS-1:0]   bits
);
  logic               busy_q;
  logic [SLICE_W-1:0] row_q;
  logic [ID_W-1:0]    ent_q;
  logic [KEY_W-1:0]   val_q;
  logic [KEY_W-1:0]   care_q;
  logic               set_q;
  logic               last_row;
  logic               wr_take;

  // Row r agrees with a value/care slice when every cared bit is equal.
  function automatic logic row_accepts(input logic [SLICE_W-1:0] r,
                                       input logic [SLICE_W-1:0] v,
                                       input logic [SLICE_W-1:0] c);
    return ((r ^ v) & c) == '0;
  endfunction

  assign wr_take  = wr_valid && !busy_q;
  assign last_row = busy_q && (row_q == SLICE_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      ent_q  <= '0;
      val_q  <= '0;
      care_q <= '0;
      set_q  <= 1'b0;
    end else if (wr_take) begin
      busy_q <= 1'b1;
      row_q  <= '0;
      ent_q  <= wr_entry;
      val_q  <= wr_value;
      care_q <= wr_care;
      set_q  <= wr_enable;
    end else if (busy_q) begin
      row_q <= row_q + 1'b1;
      if (last_row) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < PARTS; g++) begin : g_bit
    assign bits[g] = set_q &&
      row_accepts(row_q, val_q[g*SLICE_W +: SLICE_W], care_q[g*SLICE_W +: SLICE_W]);
  end

  assign busy = busy_q;
  assign row  = row_q;
  assign ent  = ent_q;

  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> busy_q && row_q == '0);
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last_row |=> busy_q && row_q == SLICE_W'($past(row_q) + 1'b1));
  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    last_row |=> !busy_q);
  a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_valid |=> $stable(ent_q) && $stable(val_q) && $stable(care_q) && $stable(set_q));
endmodule

// File: rtl/bmp_resolve.sv
module bmp_resolve #(
  parameter int unsigned PARTS   = 4,
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned ID_W = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PARTS*ENTRIES-1:0] rows,
  input  logic                     cas_hit,
  input  logic [ID_W-1:0]          cas_id,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic [ID_W-1:0]          res_id
);
  logic [ENTRIES-1:0] all_hits;
  logic               local_hit;
  logic [ID_W-1:0]    local_id;

  function automatic logic [ENTRIES-1:0] and_rows(input logic [PARTS*ENTRIES-1:0] v);
    logic [ENTRIES-1:0] acc;
    acc = '1;
    for (int g = 0; g < PARTS; g++) acc &= v[g*ENTRIES +: ENTRIES];
    return acc;
  endfunction

  // Lowest set position wins; zero when nothing is set.
  function automatic logic [ID_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [ID_W-1:0] idx;
    idx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) if (v[j]) idx = ID_W'(j);
    return idx;
  endfunction

  assign all_hits  = and_rows(rows);
  assign local_hit = |all_hits;
  assign local_id  = lowest_set(all_hits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_id    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_hit <= cas_hit | local_hit;
        res_id  <= cas_hit ? cas_id : local_id;
      end
    end
  end

  a_r10_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cas_hit |=> res_valid && res_hit && res_id == $past(cas_id));
  a_r4_miss_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_id == '0);
  a_r3_winner_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cas_hit && local_hit |=> res_hit && $past(all_hits[local_id]));
endmodule

// File: rtl/bmp_tcam_unit.sv
module bmp_tcam_unit
  import bmp_tcam_pkg::*;
#(
  parameter int unsigned KEY_W   = KEY_BITS,
  parameter int unsigned SLICE_W = SLICE_BITS,
  parameter int unsigned ENTRIES = NUM_ENTRY,
  localparam int unsigned PARTS = KEY_W / SLICE_W,
  localparam int unsigned ID_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_valid,
  input  logic [KEY_W-1:0] srch_key,
  input  logic             cas_hit_in,
  input  logic [ID_W-1:0]  cas_id_in,
  input  logic             wr_valid,
  input  logic [ID_W-1:0]  wr_entry,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_care,
  input  logic             wr_enable,
  output logic             busy,
  output logic             res_valid,
  output logic             res_hit,
  output logic [ID_W-1:0]  res_id
);
  logic                     srch_fire;
  logic                     s1_valid;
  logic                     s1_cas_hit;
  logic [ID_W-1:0]          s1_cas_id;
  logic [PARTS*ENTRIES-1:0] rows;
  logic [SLICE_W-1:0]       w_row;
  logic [ID_W-1:0]          w_ent;
  logic [PARTS-1:0]         w_bits;

  assign srch_fire = srch_valid && !busy;

  bmp_writer #(.KEY_W(KEY_W), .SLICE_W(SLICE_W), .ENTRIES(ENTRIES)) u_writer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_entry(wr_entry),
    .wr_value(wr_value), .wr_care(wr_care), .wr_enable(wr_enable),
    .busy(busy), .row(w_row), .ent(w_ent), .bits(w_bits));

  for (genvar g = 0; g < PARTS; g++) begin : g_part
    bmp_part #(.SLICE_W(SLICE_W), .ENTRIES(ENTRIES)) u_part (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(srch_key[g*SLICE_W +: SLICE_W]),
      .rd_row(rows[g*ENTRIES +: ENTRIES]),
      .wr_on(busy), .wr_addr(w_row), .wr_ent(w_ent), .wr_bit(w_bits[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_cas_hit <= 1'b0;
      s1_cas_id  <= '0;
    end else begin
      s1_valid   <= srch_fire;
      s1_cas_hit <= cas_hit_in;
      s1_cas_id  <= cas_id_in;
    end
  end

  bmp_resolve #(.PARTS(PARTS), .ENTRIES(ENTRIES)) u_resolve (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .rows(rows),
    .cas_hit(s1_cas_hit), .cas_id(s1_cas_id),
    .res_valid(res_valid), .res_hit(res_hit), .res_id(res_id));

  a_r5_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    srch_fire |-> ##2 res_valid);
  a_r7_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(srch_fire, 2));
endmodule

// File: tb/test_bmp_tcam_unit.sv
module test_bmp_tcam_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srch_valid = 1'b0;
  logic [15:0] srch_key = '0;
  logic        cas_hit_in = 1'b0;
  logic [4:0]  cas_id_in = '0;
  logic        wr_valid = 1'b0;
  logic [4:0]  wr_entry = '0;
  logic [15:0] wr_value = '0;
  logic [15:0] wr_care = '0;
  logic        wr_enable = 1'b0;
  logic        busy, res_valid, res_hit;
  logic [4:0]  res_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_val [32];
  logic [15:0] m_care [32];
  logic        m_on [32];

  // {key, expected hit, expected id} after entries 3, 5, 9, 1 are stored
  localparam logic [21:0] VEC [6] = '{
    {16'h1234, 1'b1, 5'd3},   // R3: 3, 5, 9 match
    {16'h1299, 1'b1, 5'd5},   // R2: prefix 12xx
    {16'hA0C0, 1'b1, 5'd1},   // R2: AxCx
    {16'hAFCF, 1'b1, 5'd1},   // R2: don't-care slices vary
    {16'h5555, 1'b1, 5'd9},   // R11: match-all entry
    {16'hBBCD, 1'b1, 5'd9}    // R2: cared slice differs from entry 1
  };

  bmp_tcam_unit i_bmp_tcam_unit (
    .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
    .cas_hit_in(cas_hit_in), .cas_id_in(cas_id_in), .wr_valid(wr_valid),
    .wr_entry(wr_entry), .wr_value(wr_value), .wr_care(wr_care),
    .wr_enable(wr_enable), .busy(busy), .res_valid(res_valid),
    .res_hit(res_hit), .res_id(res_id));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] model(input logic [15:0] key);
    for (int j = 0; j < 32; j++)
      if (m_on[j] && ((key ^ m_val[j]) & m_care[j]) == 16'h0) return {1'b1, 5'(j)};
    return 6'h0;
  endfunction

  task automatic search(input logic [15:0] key, input logic ch, input logic [4:0] cid,
                        input logic eh, input logic [4:0] eid, input string tag);
    @(negedge clk);
    srch_valid = 1'b1; srch_key = key; cas_hit_in = ch; cas_id_in = cid;
    @(negedge clk);
    srch_valid = 1'b0; cas_hit_in = 1'b0;
    chk({"R5 early ", tag}, 32'(res_valid), 32'd0);
    @(negedge clk);
    chk({"R5 valid ", tag}, 32'(res_valid), 32'd1);
    chk({tag, " hit"}, 32'(res_hit), 32'(eh));
    chk({tag, " id"}, 32'(res_id), 32'(eid));
  endtask

  task automatic search_model(input logic [15:0] key, input string tag);
    logic [5:0] e;
    e = model(key);
    search(key, 1'b0, 5'd0, e[5], e[4:0], tag);
  endtask

  task automatic start_write(input logic [4:0] ent, input logic [15:0] v,
                             input logic [15:0] c, input logic en);
    @(negedge clk);
    wr_valid = 1'b1; wr_entry = ent; wr_value = v; wr_care = c; wr_enable = en;
    @(negedge clk);
    wr_valid = 1'b0;
    m_on[ent] = en; m_val[ent] = v; m_care[ent] = c;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic write_entry(input logic [4:0] ent, input logic [15:0] v,
                             input logic [15:0] c, input logic en);
    int n;
    start_write(ent, v, c, en);
    wait_idle(n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int j = 0; j < 32; j++) begin m_on[j] = 0; m_val[j] = '0; m_care[j] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    search(16'h1234, 1'b0, 5'd0, 1'b0, 5'd0, "R1 R4 empty table");

    // R6: busy length on the first write
    start_write(5'd3, 16'h1234, 16'hFFFF, 1'b1);
    wait_idle(n);
    chk("R6 busy cycles", 32'(n), 32'd16);
    write_entry(5'd5, 16'h1200, 16'hFF00, 1'b1);
    write_entry(5'd9, 16'h0000, 16'h0000, 1'b1);
    write_entry(5'd1, 16'hABCD, 16'hF0F0, 1'b1);

    for (int k = 0; k < 6; k++)
      search(VEC[k][21:6], 1'b0, 5'd0, VEC[k][5], VEC[k][4:0], "R2 R3 R11 vector");

    search(16'h5555, 1'b1, 5'd17, 1'b1, 5'd17, "R10 cascade over local hit");
    search(16'h1234, 1'b1, 5'd0, 1'b1, 5'd0, "R10 cascade id zero");

    write_entry(5'd9, 16'h0000, 16'h0000, 1'b0);
    search(16'h5555, 1'b0, 5'd0, 1'b0, 5'd0, "R9 R4 cleared match-all");
    search(16'h5555, 1'b1, 5'd12, 1'b1, 5'd12, "R10 cascade over local miss");
    search(16'h1234, 1'b0, 5'd0, 1'b1, 5'd3, "R9 others kept");
    write_entry(5'd3, 16'h0000, 16'h0000, 1'b0);
    search(16'h1234, 1'b0, 5'd0, 1'b1, 5'd5, "R9 R3 next winner");

    write_entry(5'd31, 16'hFFFF, 16'hFFFF, 1'b1);
    write_entry(5'd0, 16'h7777, 16'hFFFF, 1'b1);
    search(16'hFFFF, 1'b0, 5'd0, 1'b1, 5'd31, "R2 top entry");
    search(16'h7777, 1'b0, 5'd0, 1'b1, 5'd0, "R2 entry zero");

    // R7: search offered during a write
    start_write(5'd20, 16'h5555, 16'hFFFF, 1'b1);
    srch_valid = 1'b1; srch_key = 16'h5555;
    @(negedge clk);
    srch_valid = 1'b0;
    n = 0;
    repeat (3) begin
      if (res_valid) n++;
      @(negedge clk);
    end
    chk("R7 blocked search pulses", 32'(n), 32'd0);
    wait_idle(n);
    search_model(16'h5555, "R7 R2 after write");

    // R8: write offered during a write
    start_write(5'd21, 16'hAAAA, 16'hFFFF, 1'b1);
    wr_valid = 1'b1; wr_entry = 5'd22; wr_value = 16'h4444; wr_care = 16'hFFFF; wr_enable = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    wait_idle(n);
    search(16'h4444, 1'b0, 5'd0, 1'b0, 5'd0, "R8 dropped write");
    search_model(16'hAAAA, "R8 accepted write");

    for (int k = 0; k < 8; k++)
      search_model(16'(k * 16'h2345 + 16'h1200), "R2 model sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule